// File: doc/BRIEF.md
# Enable-Framed Three-Wire Serial Byte Receiver

This block is a receive-only slave for a three-wire synchronous link made of an enable line, a serial clock and a serial data line. It runs on a system clock that is much faster than the serial clock. All three line inputs pass through a synchronizer chain before any logic uses them. While enable is high, the block samples the data line on each rising edge of the serial clock. The first bit on the wire becomes bit 0 of the assembled byte.

When a byte is complete, the block loads it into an output register and raises a strobe for one system clock cycle. A downstream command decoder picks up the byte on that strobe. Bytes can follow one another without a gap while enable stays high.

A rising edge on enable restarts the shift state. Lowering enable abandons whatever partial byte has been collected. Serial clock activity while enable is low has no effect.

Top module: `ser3w_rx`

## Requirements
- R1: While `rst_n` is low, `rx_vld` is 0 and `rx_byte` is 0. This holds even if reset arrives in the middle of a byte.
- R2: Data is sampled on rising edges of `sck` only. The first bit sampled after enable rises lands in bit 0 of `rx_byte`, and the eighth bit sampled lands in bit 7.
- R3: After the eighth rising `sck` edge of a byte, `rx_vld` is high for exactly one `clk` cycle. In that same cycle `rx_byte` carries the new byte.
- R4: While `cs_en` stays high, each further group of eight rising `sck` edges delivers another byte. No idle bit is needed between bytes.
- R5: If `cs_en` falls before a byte is complete, the partial bits are never delivered. A later frame starts from an empty shift state.
- R6: Rising `sck` edges seen while `cs_en` is low produce no strobe. They also do not change the bits of the next frame.
- R7: `rx_byte` keeps its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sck` |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_en | input | 1 | Frame enable, active high, asynchronous to `clk` |
| sck | input | 1 | Serial clock; data is sampled on its rising edge |
| sdin | input | 1 | Serial data, least significant bit first |
| rx_byte | output | DATA_W | Last completed byte |
| rx_vld | output | 1 | One-cycle strobe for each completed byte |

## Verification
The bound checker watches several properties on every cycle:
- the strobe never lasts two cycles;
- the output byte changes only together with the strobe;
- the bit counter is back at zero one cycle after enable is seen low or rising, and whenever a byte is handed out;
- no strobe follows a cycle in which enable is low.

The following can only be shown by the bench's scenarios, which compare delivered bytes against values worked out from the wire order:
- the bit order;
- back-to-back delivery;
- the discarding of a partial byte;
- the immunity to clock edges while enable is low.

// File: rtl/ser3w_pkg.sv
package ser3w_pkg;
   // line bundle after synchronisation
   typedef struct packed {
      logic en;
      logic sck;
      logic sd;
   } ser3w_lines_t;

   localparam int LINES_W = $bits(ser3w_lines_t);
endpackage

// File: rtl/ser3w_sync.sv
module ser3w_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] d_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ser3w_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else if (s == 0) chain[s] <= d_async;
         else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/ser3w_edge.sv
module ser3w_edge
   import ser3w_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  ser3w_lines_t lines,
   output logic         en_lvl,
   output logic         en_rise,
   output logic         sck_rise,
   output logic         sd_bit
);
   logic en_d, sck_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_d  <= 1'b0;
         sck_d <= 1'b0;
      end else begin
         en_d  <= lines.en;
         sck_d <= lines.sck;
      end
   end

   assign en_lvl   = lines.en;
   assign en_rise  = lines.en & ~en_d;
   assign sck_rise = lines.sck & ~sck_d;
   assign sd_bit   = lines.sd;
endmodule

// File: rtl/ser3w_shift.sv
module ser3w_shift #(
   parameter int DATA_W = 8,
   localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_lvl,
   input  logic              en_rise,
   input  logic              sck_rise,
   input  logic              sd_bit,
   output logic [DATA_W-1:0] byte_q,
   output logic              vld_q,
   output logic [CNT_W-1:0]  cnt_q
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   logic [DATA_W-1:0] sh_q;
   logic [DATA_W-1:0] sh_nxt;

   // least significant bit arrives first: shift toward bit 0
   assign sh_nxt = {sd_bit, sh_q[DATA_W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         cnt_q  <= '0;
         byte_q <= '0;
         vld_q  <= 1'b0;
      end else begin
         vld_q <= 1'b0;
         if (!en_lvl || en_rise) begin
            sh_q  <= '0;
            cnt_q <= '0;
         end else if (sck_rise) begin
            sh_q <= sh_nxt;
            if (cnt_q == LAST) begin
               cnt_q  <= '0;
               byte_q <= sh_nxt;
               vld_q  <= 1'b1;
            end else begin
               cnt_q <= cnt_q + CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/ser3w_rx.sv
module ser3w_rx
   import ser3w_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_en,
   input  logic              sck,
   input  logic              sdin,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_vld
);
   localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

   if (DATA_W < 2) begin : g_bad_width
      $error("ser3w_rx: DATA_W must be at least 2");
   end

   ser3w_lines_t raw_lines, sync_lines;
   logic en_s, en_rise, sck_rise, sd_bit;
   logic [CNT_W-1:0] bit_cnt;

   assign raw_lines = '{en: cs_en, sck: sck, sd: sdin};

   ser3w_sync #(.WIDTH(LINES_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (raw_lines),
      .d_sync  (sync_lines)
   );

   ser3w_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .lines    (sync_lines),
      .en_lvl   (en_s),
      .en_rise  (en_rise),
      .sck_rise (sck_rise),
      .sd_bit   (sd_bit)
   );

   ser3w_shift #(.DATA_W(DATA_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_lvl   (en_s),
      .en_rise  (en_rise),
      .sck_rise (sck_rise),
      .sd_bit   (sd_bit),
      .byte_q   (rx_byte),
      .vld_q    (rx_vld),
      .cnt_q    (bit_cnt)
   );
endmodule

// File: rtl/ser3w_rx_chk.sv
module ser3w_rx_chk #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en_s,
   input logic              en_rise,
   input logic [CNT_W-1:0]  cnt,
   input logic [DATA_W-1:0] rx_byte,
   input logic              rx_vld
);
   // R3
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_vld |=> !rx_vld);

   // R3
   strobe_cnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_vld |-> cnt == '0);

   // R7
   byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_vld |-> $stable(rx_byte));

   // R5
   no_strobe_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_s |=> !rx_vld);

   // R6
   cnt_clear_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_s |=> cnt == '0);

   // R5
   cnt_clear_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_rise |=> cnt == '0);
endmodule

bind ser3w_rx ser3w_rx_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .en_s    (en_s),
   .en_rise (en_rise),
   .cnt     (bit_cnt),
   .rx_byte (rx_byte),
   .rx_vld  (rx_vld)
);

// File: tb/ser3w_rx_tb.sv
module ser3w_rx_tb;
   localparam int CLK_P = 10;
   localparam int HB    = 6;   // system cycles per serial half bit
   localparam int NV    = 6;
   // {bits in wire order (bit 7 sent first), expected byte}
   localparam logic [15:0] VEC [NV] = '{
      16'h80_01, 16'h01_80, 16'hF0_0F, 16'h35_AC, 16'h12_48, 16'hFF_FF
   };

   logic clk = 1'b0, rst_n = 1'b0, cs_en = 1'b0, sck = 1'b1, sdin = 1'b0;
   logic [7:0] rx_byte;
   logic rx_vld;

   int total = 0, bad = 0, got_n = 0;
   logic [7:0] got [64];
   logic prev_vld = 1'b0;
   int long_strobe = 0;
   bit done = 0;

   always #(CLK_P/2) clk = ~clk;

   ser3w_rx u_dut (.clk(clk), .rst_n(rst_n), .cs_en(cs_en), .sck(sck),
                   .sdin(sdin), .rx_byte(rx_byte), .rx_vld(rx_vld));

   always @(negedge clk) begin
      if (rx_vld) begin
         if (got_n < 64) got[got_n] = rx_byte;
         got_n++;
         if (prev_vld) long_strobe++;
      end
      prev_vld = rx_vld;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bits(input logic [7:0] wire_bits, input int n);
      for (int i = 0; i < n; i++) begin
         sck = 1'b0; sdin = wire_bits[7-i];
         idle(HB);
         sck = 1'b1;
         idle(HB);
      end
   endtask

   task automatic frame_on();  cs_en = 1'b1; idle(HB); endtask
   task automatic frame_off(); idle(8); cs_en = 1'b0; idle(HB); endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int base;
      idle(4);
      chk("R1 reset vld", rx_vld, 0);
      chk("R1 reset byte", rx_byte, 0);
      rst_n = 1'b1; idle(4);

      // table walk: one byte per frame, R2 and R3
      for (int v = 0; v < NV; v++) begin
         base = got_n;
         frame_on(); send_bits(VEC[v][15:8], 8); frame_off();
         chk("R3 one byte per frame", got_n - base, 1);
         chk("R2 lsb first order", got[base], VEC[v][7:0]);
      end

      // R4: back to back bytes in one frame
      base = got_n;
      frame_on();
      send_bits(8'h80, 8); send_bits(8'h35, 8); send_bits(8'hF0, 8);
      frame_off();
      chk("R4 back to back count", got_n - base, 3);
      chk("R4 byte0", got[base], 8'h01);
      chk("R4 byte1", got[base+1], 8'hAC);
      chk("R4 byte2", got[base+2], 8'h0F);

      // R5: partial byte abandoned, next frame starts clean
      base = got_n;
      frame_on(); send_bits(8'hFF, 5); frame_off();
      chk("R5 partial not delivered", got_n - base, 0);
      chk("R7 byte kept after partial", rx_byte, 8'h0F);
      frame_on(); send_bits(8'h12, 8); frame_off();
      chk("R5 fresh frame count", got_n - base, 1);
      chk("R5 fresh frame byte", rx_byte, 8'h48);

      // R6: clock edges while enable low
      base = got_n;
      send_bits(8'hFF, 8); send_bits(8'hFF, 3);
      idle(8);
      chk("R6 no strobe while off", got_n - base, 0);
      chk("R6 byte untouched while off", rx_byte, 8'h48);
      frame_on(); send_bits(8'h01, 8); frame_off();
      chk("R6 next frame unaffected", rx_byte, 8'h80);

      // R7: hold over idle time
      idle(50);
      chk("R7 hold", rx_byte, 8'h80);
      chk("R3 strobe width", long_strobe, 0);

      // R1: reset in the middle of a byte
      frame_on(); send_bits(8'hAA, 4);
      rst_n = 1'b0; idle(2);
      chk("R1 mid reset byte", rx_byte, 0);
      chk("R1 mid reset vld", rx_vld, 0);
      cs_en = 1'b0; idle(4); rst_n = 1'b1; idle(4);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule